// File: doc/BRIEF.md
# Truth-Table Alarm and Indicator Evaluator

This block turns eight live condition bits into three independent decisions: whether to raise the alarm output, whether to light a red error LED and whether to light a green status LED. The eight bits are six deglitched alarm inputs, the state of the guide-laser output and the interlock input. Together they form an 8-bit index. For each output the block holds a programmable 256-entry, one-bit truth table, so each output can be any sum-of-products over the eight bits.

Each table is stored as sixteen 16-bit words and is written through a simple register port that carries an address, a write strobe and 16-bit data. The same address returns the stored word on a registered read path. A yellow LED output mirrors the alarm output. While the shutter input reports open, the yellow LED blinks at a rate set by a parameterised prescaler instead of staying on. All table bits clear on reset, so no output is active until software loads the tables.

Top module: `alarm_lut_eval`

## Requirements
- R1: While `rst` is high and on the first clock after it, all four outputs are 0, `rd_data` is 0 and every table bit is 0.
- R2: The lookup index has bit 7 = `interlock_open`, bit 6 = `guide_on`, bits 5 and 4 = `alarm_in[5]` and `alarm_in[4]`, and bits 3..0 = `alarm_in[3:0]`. Index bits 7..4 choose the table word and bits 3..0 choose the bit within that word.
- R3: A write with `wr_en` high stores `wr_data` at the addressed word. Addresses 0x10–0x1F hold the alarm table, 0x20–0x2F the error-LED table and 0x30–0x3F the green-LED table, with word k at base+k. No other word changes.
- R4: The three tables are independent. `alarm_out`, `err_led` and `ok_led` each equal the bit of their own table at the current index.
- R5: Outputs are registered. A change of the index or of a table word appears at the outputs on the clock edge after the one that samples it, and a word written on an edge is not yet seen by the lookup made on that same edge.
- R6: While `shutter_open` is 0, `yellow_led` equals the alarm lookup, with the same timing as `alarm_out`.
- R7: While `shutter_open` is 1 and the alarm lookup is 1, `yellow_led` alternates, high for 2^BLINK_LOG2 cycles and low for 2^BLINK_LOG2 cycles. It is never high while `alarm_out` is 0.
- R8: `rd_data` shows, one clock after `addr` is presented, the stored word at that address. Any address outside 0x10–0x3F reads as 0, and writes to such addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the table word at `addr` |
| addr | input | 7 | Register address for writes and reads |
| wr_data | input | 16 | Word to store |
| rd_data | output | 16 | Registered read-back of the word at `addr` |
| alarm_in | input | 6 | Deglitched alarm inputs, index bits 5..0 |
| guide_on | input | 1 | Guide-laser output state, index bit 6 |
| interlock_open | input | 1 | Interlock open, index bit 7 |
| shutter_open | input | 1 | Shutter open: yellow LED blinks |
| alarm_out | output | 1 | Alarm table result |
| err_led | output | 1 | Error-LED table result |
| ok_led | output | 1 | Green-LED table result |
| yellow_led | output | 1 | Alarm indicator, steady or blinking |

## Verification
The bench loads all 48 words with distinct patterns and sweeps all 256 index values. A swapped index bit, or a word and bit select taken from the wrong halves of the index, therefore shows up as a wrong output at many indices. One lookup is made on the same edge as a write to its own word, which catches a design that forwards new table data a cycle early. Reads and writes are aimed at unmapped addresses that share low address bits with real table words, so incomplete address decoding shows up either as a corrupted word or as a nonzero read. With the shutter open, the bench counts high cycles over a full blink period and watches for a blinking yellow LED while no alarm is active. A prescaler of the wrong length or a blink that is not gated by the alarm is caught there.

// File: rtl/alarm_lut_pkg.sv
package alarm_lut_pkg;

    localparam int IDX_W      = 8;
    localparam int BIT_SEL_W  = 4;
    localparam int WORD_SEL_W = IDX_W - BIT_SEL_W;
    localparam int WORD_W     = 1 << BIT_SEL_W;
    localparam int N_WORDS    = 1 << WORD_SEL_W;
    localparam int ADDR_W     = 7;
    localparam int N_TABLES   = 3;
    localparam int N_ALARMS   = 6;

    // Table chosen by the upper address bits; NONE marks unmapped space.
    typedef enum logic [1:0] {
        TBL_ALARM = 2'd0,
        TBL_ERR   = 2'd1,
        TBL_OK    = 2'd2,
        TBL_NONE  = 2'd3
    } tbl_e;

    // Lookup index, MSB first: interlock is bit 7, alarm bits 3..0 at the bottom.
    typedef struct packed {
        logic       interlock_open;
        logic       guide_on;
        logic [1:0] aux_alm;
        logic [3:0] main_alm;
    } lut_index_t;

    typedef struct packed {
        logic alarm;
        logic err;
        logic ok;
        logic yellow;
    } lut_outs_t;

    function automatic tbl_e decode_table(input logic [ADDR_W-1:0] a);
        case (a[ADDR_W-1:WORD_SEL_W])
            3'd1:    return TBL_ALARM;
            3'd2:    return TBL_ERR;
            3'd3:    return TBL_OK;
            default: return TBL_NONE;
        endcase
    endfunction

    function automatic logic [WORD_SEL_W-1:0] word_of(input logic [ADDR_W-1:0] a);
        return a[WORD_SEL_W-1:0];
    endfunction

endpackage

// File: rtl/lut_index_former.sv
module lut_index_former
    import alarm_lut_pkg::*;
(
    input  logic [N_ALARMS-1:0] alarm_in,
    input  logic                guide_on,
    input  logic                interlock_open,
    output lut_index_t          idx
);
    always_comb begin
        idx.interlock_open = interlock_open;
        idx.guide_on       = guide_on;
        idx.aux_alm        = alarm_in[N_ALARMS-1:4];
        idx.main_alm       = alarm_in[3:0];
    end
endmodule

// File: rtl/lut_table_bank.sv
module lut_table_bank
    import alarm_lut_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_sel,
    input  logic [WORD_SEL_W-1:0]  wr_word,
    input  logic [WORD_W-1:0]      wr_data,
    input  logic [WORD_SEL_W-1:0]  rd_word,
    output logic [WORD_W-1:0]      rd_data,
    input  logic [IDX_W-1:0]       look_idx,
    output logic                   hit
);
    logic [N_WORDS-1:0][WORD_W-1:0] words;
    logic [WORD_W-1:0]              look_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            words <= '0;
        end else if (wr_sel) begin
            words[wr_word] <= wr_data;
        end
    end

    always_comb begin
        look_word = words[look_idx[IDX_W-1:BIT_SEL_W]];
        hit       = look_word[look_idx[BIT_SEL_W-1:0]];
        rd_data   = words[rd_word];
    end

    // R3: the addressed word holds the written data after the write edge
    a_r3_word_written: assert property (@(posedge clk) disable iff (rst)
        $past(wr_sel) |-> words[$past(wr_word)] == $past(wr_data));

    // R3: without a write strobe to this table no word moves
    a_r3_no_stray_change: assert property (@(posedge clk) disable iff (rst)
        !$past(wr_sel) |-> $stable(words));

    // R1: reset leaves the table empty
    a_r1_table_cleared: assert property (@(posedge clk)
        $past(rst) |-> words == '0);
endmodule

// File: rtl/blink_gen.sv
module blink_gen #(
    parameter int LOG2 = 22
) (
    input  logic clk,
    input  logic rst,
    output logic phase
);
    logic [LOG2-1:0] cnt;
    logic            wrap;

    assign wrap = (cnt == {LOG2{1'b1}});

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
            if (wrap) phase <= ~phase;
        end
    end

    // R7: the phase flips only when the prescaler wraps
    a_r7_phase_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (phase != $past(phase)) |-> ($past(cnt) == {LOG2{1'b1}}));
endmodule

// File: rtl/alarm_lut_eval.sv
module alarm_lut_eval
    import alarm_lut_pkg::*;
#(
    parameter int BLINK_LOG2 = 22
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wr_data,
    output logic [WORD_W-1:0]   rd_data,
    input  logic [N_ALARMS-1:0] alarm_in,
    input  logic                guide_on,
    input  logic                interlock_open,
    input  logic                shutter_open,
    output logic                alarm_out,
    output logic                err_led,
    output logic                ok_led,
    output logic                yellow_led
);
    lut_index_t        idx;
    tbl_e              tbl;
    logic              phase;
    logic [N_TABLES-1:0] hits;
    logic [WORD_W-1:0] bank_rd [N_TABLES];
    logic [WORD_W-1:0] rd_next;
    lut_outs_t         outs_q;

    assign tbl = decode_table(addr);

    lut_index_former u_index (
        .alarm_in       (alarm_in),
        .guide_on       (guide_on),
        .interlock_open (interlock_open),
        .idx            (idx)
    );

    for (genvar t = 0; t < N_TABLES; t++) begin : g_bank
        logic sel;
        assign sel = wr_en && (tbl == tbl_e'(t));
        lut_table_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .wr_sel   (sel),
            .wr_word  (word_of(addr)),
            .wr_data  (wr_data),
            .rd_word  (word_of(addr)),
            .rd_data  (bank_rd[t]),
            .look_idx (idx),
            .hit      (hits[t])
        );
    end

    blink_gen #(.LOG2(BLINK_LOG2)) u_blink (
        .clk   (clk),
        .rst   (rst),
        .phase (phase)
    );

    always_comb begin
        if (tbl == TBL_NONE) rd_next = '0;
        else                 rd_next = bank_rd[tbl];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            outs_q  <= '0;
            rd_data <= '0;
        end else begin
            outs_q.alarm  <= hits[TBL_ALARM];
            outs_q.err    <= hits[TBL_ERR];
            outs_q.ok     <= hits[TBL_OK];
            outs_q.yellow <= hits[TBL_ALARM] & (~shutter_open | phase);
            rd_data       <= rd_next;
        end
    end

    assign alarm_out  = outs_q.alarm;
    assign err_led    = outs_q.err;
    assign ok_led     = outs_q.ok;
    assign yellow_led = outs_q.yellow;

    // R1: outputs are quiet right after reset
    a_r1_outputs_quiet: assert property (@(posedge clk)
        $past(rst) |-> !(alarm_out || err_led || ok_led || yellow_led) && rd_data == '0);

    // R7: the yellow LED never lights without the alarm
    a_r7_yellow_needs_alarm: assert property (@(posedge clk) disable iff (rst)
        yellow_led |-> alarm_out);

    // R6: with the shutter closed the yellow LED is steady with the alarm
    a_r6_steady_closed: assert property (@(posedge clk) disable iff (rst)
        (!$past(shutter_open) && alarm_out) |-> yellow_led);

    // R8: unmapped addresses read back as zero
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        ($past(decode_table(addr)) == TBL_NONE) |-> rd_data == '0);
endmodule

// File: tb/alarm_lut_eval_test.sv
module alarm_lut_eval_test;
    localparam int BL = 3;
    localparam int HALF = 1 << BL;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [6:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [5:0]  alarm_in = '0;
    logic        guide_on = 1'b0;
    logic        interlock_open = 1'b0;
    logic        shutter_open = 1'b0;
    logic        alarm_out, err_led, ok_led, yellow_led;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    alarm_lut_eval #(.BLINK_LOG2(BL)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .alarm_in(alarm_in), .guide_on(guide_on),
        .interlock_open(interlock_open), .shutter_open(shutter_open),
        .alarm_out(alarm_out), .err_led(err_led), .ok_led(ok_led),
        .yellow_led(yellow_led)
    );

    typedef struct {
        bit          chk_out;
        bit          chk_yel;
        bit          chk_rd;
        logic [2:0]  exp_out;
        logic        exp_yel;
        logic [15:0] exp_rd;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [15:0] mdl [3][16];

    function automatic logic [15:0] pat(input int t, input int k);
        return 16'((k * 16'h0F0F + 16'h1357 * (t + 1)) ^ (16'h8001 << k));
    endfunction

    function automatic int tbl_of(input logic [6:0] a);
        if (a[6:4] >= 3'd1 && a[6:4] <= 3'd3) return int'(a[6:4]) - 1;
        return -1;
    endfunction

    task automatic drive(input bit we, input logic [6:0] a, input logic [15:0] d,
                         input logic [7:0] idx, input bit shut,
                         input bit co, input bit cr, input string tag);
        exp_t e;
        int t;
        @(negedge clk);
        wr_en = we; addr = a; wr_data = d; shutter_open = shut;
        alarm_in = idx[5:0]; guide_on = idx[6]; interlock_open = idx[7];
        e.chk_out = co;
        e.chk_yel = co && !shut;
        e.chk_rd  = cr;
        e.exp_out = {mdl[0][idx[7:4]][idx[3:0]], mdl[1][idx[7:4]][idx[3:0]],
                     mdl[2][idx[7:4]][idx[3:0]]};
        e.exp_yel = mdl[0][idx[7:4]][idx[3:0]];
        t = tbl_of(a);
        e.exp_rd  = (t < 0) ? 16'h0 : mdl[t][a[3:0]];
        e.tag = tag;
        sb.push_back(e);
        if (we && t >= 0) mdl[t][a[3:0]] = d;
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            if (e.chk_out) begin
                checks++;
                if ({alarm_out, err_led, ok_led} !== e.exp_out) begin
                    failures++;
                    $display("FAIL %s alarm/err/ok actual=%b expected=%b",
                             e.tag, {alarm_out, err_led, ok_led}, e.exp_out);
                end
            end
            if (e.chk_yel) begin
                checks++;
                if (yellow_led !== e.exp_yel) begin
                    failures++;
                    $display("FAIL R6 %s yellow actual=%b expected=%b", e.tag, yellow_led, e.exp_yel);
                end
            end
            if (e.chk_rd) begin
                checks++;
                if (rd_data !== e.exp_rd) begin
                    failures++;
                    $display("FAIL %s rd_data actual=%h expected=%h", e.tag, rd_data, e.exp_rd);
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        int hi;
        bit bad;
        for (int t = 0; t < 3; t++) for (int k = 0; k < 16; k++) mdl[t][k] = '0;
        repeat (3) @(posedge clk);
        // R1: outputs quiet during reset
        @(negedge clk);
        checks++;
        if ({alarm_out, err_led, ok_led, yellow_led, rd_data} !== '0) begin
            failures++;
            $display("FAIL R1 reset outputs actual=%b expected=0",
                     {alarm_out, err_led, ok_led, yellow_led, |rd_data});
        end
        rst = 1'b0;

        // R1: empty tables after reset, every index gives 0
        drive(0, 7'h10, 0, 8'hFF, 0, 1, 1, "R1 post-reset idx ff");
        drive(0, 7'h3F, 0, 8'h00, 0, 1, 1, "R1 post-reset idx 00");

        // R3: load all three tables with distinct patterns
        for (int t = 0; t < 3; t++)
            for (int k = 0; k < 16; k++)
                drive(1, 7'(((t + 1) << 4) | k), pat(t, k), 8'(k * 17), 0, 1, 0, "R3 load");

        // R2 R4: sweep every index, checking all three tables
        for (int i = 0; i < 256; i++)
            drive(0, 7'h00, 0, 8'(i), 0, 1, 0, "R2 R4 sweep");

        // R8 R3: read back every word
        for (int a = 16'h10; a < 16'h40; a++)
            drive(0, 7'(a), 0, 8'h00, 0, 0, 1, "R8 R3 readback");
        // R8: unmapped addresses read zero
        drive(0, 7'h00, 0, 8'h00, 0, 0, 1, "R8 unmapped 00");
        drive(0, 7'h0F, 0, 8'h00, 0, 0, 1, "R8 unmapped 0f");
        drive(0, 7'h45, 0, 8'h00, 0, 0, 1, "R8 unmapped 45");
        drive(0, 7'h7F, 0, 8'h00, 0, 0, 1, "R8 unmapped 7f");
        // R8: writes to unmapped addresses are ignored
        drive(1, 7'h05, 16'hFFFF, 8'h00, 0, 0, 0, "R8 stray write");
        drive(1, 7'h45, 16'hFFFF, 8'h00, 0, 0, 0, "R8 stray write");
        drive(1, 7'h75, 16'hFFFF, 8'h00, 0, 0, 0, "R8 stray write");
        for (int a = 16'h10; a < 16'h40; a++)
            drive(0, 7'(a), 0, 8'h00, 0, 0, 1, "R8 after stray writes");

        // R5: write word 3 of the alarm table while looking it up
        drive(0, 7'h00, 0, 8'h35, 0, 0, 0, "setup");
        drive(1, 7'h13, 16'h0020, 8'h35, 0, 1, 0, "R5 same-edge old value");
        drive(0, 7'h00, 0, 8'h35, 0, 1, 0, "R5 new value next edge");
        drive(1, 7'h13, 16'h0000, 8'h35, 0, 1, 0, "R5 clear same edge");
        drive(0, 7'h00, 0, 8'h35, 0, 1, 0, "R5 cleared");
        // R5: alternate between an alarm index and a quiet one each cycle
        drive(1, 7'h1A, 16'h0001, 8'hA0, 0, 1, 0, "R5 set");
        drive(1, 7'h11, 16'h0000, 8'hA0, 0, 1, 0, "R5 set");
        for (int i = 0; i < 8; i++)
            drive(0, 7'h00, 0, (i % 2) ? 8'h10 : 8'hA0, 0, 1, 0, "R5 toggle");

        // R7: shutter open with alarm active blinks, half high over a full period
        drive(0, 7'h00, 0, 8'hA0, 1, 1, 0, "R7 settle");
        hi = 0;
        for (int i = 0; i < 2 * HALF; i++) begin
            drive(0, 7'h00, 0, 8'hA0, 1, 1, 0, "R7 blink");
            @(negedge clk);
            if (yellow_led) hi++;
        end
        checks++;
        if (hi != HALF) begin
            failures++;
            $display("FAIL R7 blink high count actual=%0d expected=%0d", hi, HALF);
        end
        // R7: no blinking while the alarm is inactive
        bad = 0;
        for (int i = 0; i < 2 * HALF; i++) begin
            drive(0, 7'h00, 0, 8'h10, 1, 1, 0, "R7 quiet");
            @(negedge clk);
            if (yellow_led) bad = 1;
        end
        checks++;
        if (bad) begin
            failures++;
            $display("FAIL R7 yellow without alarm actual=1 expected=0");
        end
        // R6: shutter closed again gives steady yellow
        for (int i = 0; i < 2 * HALF; i++)
            drive(0, 7'h00, 0, 8'hA0, 0, 1, 0, "R6 steady");

        repeat (3) @(negedge clk);
        done = 1;
        finish_run();
    end
endmodule